// File: doc/BRIEF.md
# LFSR-Addressed Word Table Generator

This block produces a stream of pseudorandom 8-bit words. A 20-bit linear feedback shift register is seeded from a parallel seed register. Once seeded, it steps once per clock. Eight of its state bits, taken from scattered positions, are gathered into an address. The address selects one word from a fixed 256-entry constant table. The table is read synchronously, and the word read becomes the output. Because the output is a table word and not the raw register state, any single word says little about the register contents.

The table holds all 256 byte values in a permuted order. The word at index i is (i*167 + 29) mod 256. Since 167 is odd, every address maps to a different word.

A client holds `load` high with a seed on `seed`, then releases `load`. After a short start-up, one new word arrives per clock, marked by `word_vld`. Raising `load` again reseeds the register and stops the stream.

Top module: `prng_word_table`

## Requirements
- R1: While reset is active and on the first clock after it is released, `word_vld` is 0 and `word` is 0.
- R2: After reset, `word_vld` stays 0 until a seed has been loaded; with `load` held low from reset, `word_vld` never rises.
- R3: Every clock edge at which `load` is 1 captures `seed` into the seed register. The seed captured at the last edge before `load` is released is the one that starts the sequence. `word_vld` is 0 on the second clock after any edge at which `load` is 1.
- R4: The register bits are numbered 1 (bit 0 of `seed`) to 20 (bit 19 of `seed`). Each step moves bit n+1 into bit n. Bit 20 takes the XNOR of the old bits 16 and 20, which is 1 when they are equal.
- R5: Address bit 0 through address bit 7 are the register bits 2, 4, 6, 7, 10, 13, 15 and 17, in that order.
- R6: A valid `word` equals (A*167 + 29) mod 256, where A is the address taken from the register state.
- R7: Let the seed S be captured at the last edge with `load` high, and call the next edge (the first at which `load` is 0) E. After E the register holds S. The edge after E outputs the word for address(S) with `word_vld` = 1. Each later edge outputs the word for the next register state. The edge at which `load` is next sampled 1 still outputs a valid word. So M edges with `load` low give exactly M valid words.
- R8: A change of `seed` while `load` is 0 has no effect on the output sequence.
- R9: A seed of all ones is a fixed point: the register never changes, and every valid word is the word for address 0xFF.
- R10: While `word_vld` is 0, `word` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Seed capture and reseed request |
| seed | input | 20 | Parallel seed value |
| word | output | 8 | Table word read from the LFSR-derived address |
| word_vld | output | 1 | Marks a fresh output word |

## Verification
The bench targets start-up timing around the release of `load`. A design with one register too many or too few would shift the whole scoreboard by a word, or would give one valid word too many or too few per burst. A burst that changes `seed` while `load` is high shows whether a design wrongly keeps the first seed, and random `seed` values driven during the run show whether the seed leaks into a running sequence. Because the table is a bijection, a swapped address bit, a wrong feedback tap or an inverted XNOR changes the expected words at once. An all-ones seed exposes a design whose feedback does not lock at that state. The bench also checks that `word` does not change while the stream is stopped.

// File: rtl/prng_word_table_pkg.sv
package prng_word_table_pkg;
  localparam int STATE_W  = 20;
  localparam int TAP_HI   = 20;
  localparam int TAP_LO   = 16;
  localparam int ADDR_W   = 8;
  localparam int WORD_W   = 8;
  localparam int TBL_MULT = 167;
  localparam int TBL_OFFS = 29;
  localparam int TBL_DEPTH = 1 << ADDR_W;

  // Register bit positions (1-based) that feed address bits 0..ADDR_W-1
  localparam int ADDR_POS [ADDR_W] = '{2, 4, 6, 7, 10, 13, 15, 17};

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [WORD_W-1:0]  word_t;

  // Constant table contents: affine permutation of the byte range
  function automatic word_t table_word(input int idx);
    return word_t'((idx * TBL_MULT + TBL_OFFS) % TBL_DEPTH);
  endfunction
endpackage

// File: rtl/prng_seed_stage.sv
module prng_seed_stage
  import prng_word_table_pkg::*;
#(
  parameter int W = STATE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_in,
  input  logic [W-1:0] seed_in,
  output logic         load_q,
  output logic [W-1:0] seed_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      seed_q <= '0;
    end else begin
      load_q <= load_in;
      if (load_in) seed_q <= seed_in;
    end
  end
endmodule

// File: rtl/prng_lfsr_core.sv
module prng_lfsr_core
  import prng_word_table_pkg::*;
#(
  parameter int W      = STATE_W,
  parameter int HI_TAP = TAP_HI,
  parameter int LO_TAP = TAP_LO
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_q,
  input  logic [W-1:0] seed_q,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ~(state[HI_TAP-1] ^ state[LO_TAP-1]);

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= '0;
    else if (load_q) state <= seed_q;
    else             state <= {fb, state[W-1:1]};
  end
endmodule

// File: rtl/prng_addr_gather.sv
module prng_addr_gather
  import prng_word_table_pkg::*;
#(
  parameter int W  = STATE_W,
  parameter int AW = ADDR_W
) (
  input  logic [W-1:0]  state,
  output logic [AW-1:0] addr
);
  for (genvar k = 0; k < AW; k++) begin : g_bit
    assign addr[k] = state[ADDR_POS[k]-1];
  end
endmodule

// File: rtl/prng_word_rom.sv
module prng_word_rom
  import prng_word_table_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_init
    assign mem[i] = DW'(table_word(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[addr];
  end
endmodule

// File: rtl/prng_word_table.sv
module prng_word_table
  import prng_word_table_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [STATE_W-1:0] seed,
  output logic [WORD_W-1:0]  word,
  output logic               word_vld
);
  logic         load_q;
  state_t       seed_q;
  state_t       state;
  addr_t        addr;
  logic         seeded;
  logic         rd_en;

  prng_seed_stage #(.W(STATE_W)) u_seed (
    .clk(clk), .rst_n(rst_n), .load_in(load), .seed_in(seed),
    .load_q(load_q), .seed_q(seed_q)
  );

  prng_lfsr_core #(.W(STATE_W), .HI_TAP(TAP_HI), .LO_TAP(TAP_LO)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load_q(load_q), .seed_q(seed_q), .state(state)
  );

  prng_addr_gather #(.W(STATE_W), .AW(ADDR_W)) u_addr (
    .state(state), .addr(addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      seeded <= 1'b0;
    else if (load_q) seeded <= 1'b1;
  end

  assign rd_en = seeded & ~load_q;

  prng_word_rom #(.AW(ADDR_W), .DW(WORD_W)) u_rom (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rd_data(word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) word_vld <= 1'b0;
    else        word_vld <= rd_en;
  end
endmodule

// File: rtl/prng_word_table_chk.sv
module prng_word_table_chk
  import prng_word_table_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic         word_vld,
  input word_t        word,
  input logic         load_q,
  input state_t       seed_q,
  input state_t       state,
  input addr_t        addr,
  input logic         seeded
);
  p_no_seed_no_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !seeded |-> !word_vld);

  p_load_stops_vld_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ##2 !word_vld);

  p_seed_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> state == $past(seed_q));

  p_shift_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |=> state[STATE_W-2:0] == $past(state[STATE_W-1:1]));

  p_table_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> word == table_word(int'($past(addr))));

  p_lockup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&state && !load_q) |=> &state);

  p_hold_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word));
endmodule

bind prng_word_table prng_word_table_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .word_vld(word_vld), .word(word),
  .load_q(load_q), .seed_q(seed_q), .state(state), .addr(addr), .seeded(seeded)
);

// File: tb/tb_prng_word_table.sv
module tb_prng_word_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [19:0] seed = '0;
  logic [7:0]  word;
  logic        word_vld;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] q_exp [$];
  string      q_tag [$];

  int tap_pos [8] = '{2, 4, 6, 7, 10, 13, 15, 17};

  prng_word_table dut (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(seed),
    .word(word), .word_vld(word_vld)
  );

  always #2 clk = ~clk;

  function automatic logic [19:0] m_step(input logic [19:0] s);
    logic [19:0] r;
    r = s >> 1;
    r[19] = (s[15] == s[19]);
    return r;
  endfunction

  function automatic logic [7:0] m_addr(input logic [19:0] s);
    logic [7:0] a;
    for (int k = 0; k < 8; k++) a[k] = s[tap_pos[k]-1];
    return a;
  endfunction

  function automatic logic [7:0] m_word(input logic [7:0] a);
    int v;
    v = (int'(a) * 167 + 29) % 256;
    return v[7:0];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected word per valid output
  always @(negedge clk) begin
    if (rst_n && word_vld) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R7 valid word beyond burst", int'(word), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(word == e, t, int'(word), int'(e));
      end
    end
  end

  // Driver: loads (seeds applied in order, last wins), then runs m cycles
  task automatic burst(input logic [19:0] s0, input logic [19:0] s1,
                       input logic [19:0] s_final, input int m, input string tag);
    logic [19:0] st;
    @(posedge clk); #1; load = 1'b1; seed = s0;
    @(posedge clk); #1; seed = s1;
    @(posedge clk); #1; seed = s_final;
    @(posedge clk); #1;
    check(q_exp.size() == 0, "R7 burst length", q_exp.size(), 0);
    st = s_final;
    for (int k = 0; k < m; k++) begin
      q_exp.push_back(m_word(m_addr(st)));
      q_tag.push_back(tag);
      st = m_step(st);
    end
    load = 1'b0;
    seed = 20'($urandom);
    for (int k = 1; k < m; k++) begin
      @(posedge clk); #1;
      seed = 20'($urandom);   // R8: must not disturb the running sequence
    end
  endtask

  initial begin
    int guard = 0;
    forever begin
      @(posedge clk);
      guard++;
      if (guard > 20000) begin
        check(1'b0, "watchdog", guard, 20000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(posedge clk);
    #1;
    check(word_vld == 1'b0, "R1 vld in reset", int'(word_vld), 0);
    check(word == 8'h00, "R1 word in reset", int'(word), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(word_vld == 1'b0 && word == 8'h00, "R1 first cycle after reset",
          int'({word_vld, word}), 0);
    for (int k = 0; k < 6; k++) begin
      seed = 20'($urandom);
      @(posedge clk); #1;
      check(word_vld == 1'b0, "R2 no output before seed", int'(word_vld), 0);
    end
    burst(20'h5A3C1, 20'h5A3C1, 20'h5A3C1, 40, "R4 R5 R6 R7 R8 main");
    burst(20'h00000, 20'h00000, 20'h00000, 30, "R4 R5 R6 R7 zero seed");
    burst(20'h12345, 20'hABCDE, 20'h0F0F1, 25, "R3 last seed wins");
    burst(20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 12, "R9 all-ones lock");
    // R9: all-ones fixed point predicted without the step model
    check(m_word(8'hFF) == m_word(m_addr(20'hFFFFF)), "R9 lock word",
          int'(m_word(m_addr(20'hFFFFF))), int'(m_word(8'hFF)));
    burst(20'h80001, 20'h80001, 20'h80001, 50, "R4 R5 R6 R7 sparse seed");
    burst(20'hC7E29, 20'hC7E29, 20'hC7E29, 1, "R7 single word");
    // Stop: hold load high and confirm the stream ends and the word holds
    @(posedge clk); #1; load = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check(q_exp.size() == 0, "R7 final burst length", q_exp.size(), 0);
    check(word_vld == 1'b0, "R3 vld low during load", int'(word_vld), 0);
    held = word;
    for (int k = 0; k < 4; k++) begin
      seed = 20'($urandom);
      @(posedge clk); #1;
      check(word == held && word_vld == 1'b0, "R10 word held", int'(word), int'(held));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule